// File: doc/BRIEF.md
# Layer-2 Address Table Command Engine

This block holds a small, fully associative table of layer-2 forwarding entries. Each entry has a 48-bit MAC address, a 12-bit VLAN ID, a 7-bit port mask and a 4-bit status field. Software reaches the table only through four 32-bit registers. Three data words carry one entry, and one function word carries a command code, a port qualifier and a start/busy bit.

Software fills the data words and then writes the function word with bit 31 set. The engine walks the table one slot per cycle and updates the slots it touches. For search and get-next it writes the result back into the data words, and then it drops busy. A status of zero means the slot is empty. Status 15 marks a static entry, which the per-port flush leaves alone.

After reset the engine clears every slot of its memory. It stays busy while it does so.

Top module: `atbl_engine`

## Requirements
- R1: The data words pack an entry as follows. Word 0 holds MAC bits 31:0. Word 1 holds MAC bits 47:32 in bits 15:0 and the port mask in bits 22:16. Word 2 holds the status in bits 3:0 and the VLAN ID in bits 23:12. All other bits read as zero. Register offsets are 0, 1 and 2 for the data words and 3 for the function word.
- R2: The function word carries the command in bits 3:0, port-enable in bit 4, the port number in bits 10:8, the full flag in bit 12 and busy in bit 31. Writing it with bit 31 set while idle starts the command. Bit 31 then reads 1 until the command ends, which takes at most DEPTH+2 cycles.
- R3: While busy, writes to any register are ignored.
- R4: Load (command 2) stores the data-word entry. It overwrites the slot that holds the same MAC and VLAN, or else takes the lowest empty slot. When no slot is free, it leaves the table unchanged and sets the full flag. The next command start clears the flag.
- R5: Purge (command 3) empties only the slot whose MAC and VLAN match the data words.
- R6: Search (command 7) copies the entry that matches on MAC and VLAN into the data words. On a miss, the data words keep MAC and VLAN, and status and mask read zero.
- R7: Get-next (command 6) treats the data words as a cursor. An all-zero cursor starts at slot 0. Otherwise the engine returns the first valid entry in a slot after the one that matches the cursor. When no entry remains, it returns the cursor's MAC and VLAN with status zero.
- R8: With port-enable set, get-next skips entries whose port mask lacks the selected port.
- R9: Flush-all (command 1) empties every slot, static ones included.
- R10: Per-port flush (command 4) leaves static entries (status 15) unchanged. With port-enable set, it clears the selected port's bit from each dynamic entry that has it, and empties any entry whose mask becomes zero. Without port-enable, it empties every dynamic entry.
- R11: After reset the engine is busy while it clears the table. It then reads idle, with all data words and the function word at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_waddr | input | 2 | Register offset for the write |
| host_wdata | input | 32 | Write data |
| host_raddr | input | 2 | Register offset for the read |
| host_rdata | output | 32 | Registered read data, one cycle after the read offset |
| busy | output | 1 | High while a command or the reset clear runs |

## Verification
The bench loads more entries than the table holds. A design that overlooked free slots, or that failed to clear the full flag, would then report the wrong flag or lose an entry. A get-next walk, both unfiltered and filtered by port, checks that the cursor is found and that the entry after it is returned. A design that returned the cursor itself, or ignored the filter, would repeat or skip entries. The bench also writes data and function words while a command runs, which catches a design that lets those writes through. Finally, it mixes static and dynamic entries under both flush forms, so that a flush which touches static entries, or which leaves an entry with an empty mask behind, shows up in later searches.

// File: rtl/atbl_pkg.sv
package atbl_pkg;
  localparam int MAC_W   = 48;
  localparam int VID_W   = 12;
  localparam int PMASK_W = 7;
  localparam int STAT_W  = 4;
  localparam int PORT_W  = 3;
  localparam int ENTRY_W = MAC_W + VID_W + PMASK_W + STAT_W;

  typedef struct packed {
    logic [VID_W-1:0]   vid;
    logic [STAT_W-1:0]  stat;
    logic [PMASK_W-1:0] pmask;
    logic [MAC_W-1:0]   mac;
  } entry_t;

  localparam logic [3:0] OP_FLUSH      = 4'd1;
  localparam logic [3:0] OP_LOAD       = 4'd2;
  localparam logic [3:0] OP_PURGE      = 4'd3;
  localparam logic [3:0] OP_FLUSH_PORT = 4'd4;
  localparam logic [3:0] OP_NEXT       = 4'd6;
  localparam logic [3:0] OP_SEARCH     = 4'd7;

  localparam logic [STAT_W-1:0] STAT_EMPTY  = '0;
  localparam logic [STAT_W-1:0] STAT_STATIC = '1;

  localparam logic [1:0] REG_D0 = 2'd0;
  localparam logic [1:0] REG_D1 = 2'd1;
  localparam logic [1:0] REG_D2 = 2'd2;
  localparam logic [1:0] REG_FN = 2'd3;

  localparam int FN_BUSY = 31;
endpackage

// File: rtl/atbl_mem.sv
module atbl_mem #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 71,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/atbl_hostif.sv
module atbl_hostif
  import atbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [1:0]        host_waddr,
  input  logic [31:0]       host_wdata,
  input  logic [1:0]        host_raddr,
  output logic [31:0]       host_rdata,
  input  logic              busy,
  input  logic              ret_vld,
  input  entry_t            ret_ent,
  input  logic              full_set,
  output logic              start,
  output entry_t            key_ent,
  output logic [3:0]        fn_cmd,
  output logic              fn_pen,
  output logic [PORT_W-1:0] fn_port,
  output logic              tbl_full
);
  entry_t              dw;
  logic [3:0]          cmd_q;
  logic                pen_q;
  logic [PORT_W-1:0]   port_q;
  logic                full_q;
  logic [31:0]         rdata_q;
  logic [31:0]         rd_mux;
  logic                unused_wbits;

  assign unused_wbits = ^host_wdata;
  assign start = host_we && (host_waddr == REG_FN) && host_wdata[FN_BUSY] && !busy;

  always_comb begin
    case (host_raddr)
      REG_D0:  rd_mux = dw.mac[31:0];
      REG_D1:  rd_mux = {9'b0, dw.pmask, dw.mac[47:32]};
      REG_D2:  rd_mux = {8'b0, dw.vid, 8'b0, dw.stat};
      default: rd_mux = {busy, 18'b0, full_q, 1'b0, port_q, 3'b0, pen_q, cmd_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dw      <= '0;
      cmd_q   <= '0;
      pen_q   <= 1'b0;
      port_q  <= '0;
      full_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (ret_vld) begin
        dw <= ret_ent;
      end else if (host_we && !busy) begin
        case (host_waddr)
          REG_D0: dw.mac[31:0] <= host_wdata;
          REG_D1: begin
            dw.mac[47:32] <= host_wdata[15:0];
            dw.pmask      <= host_wdata[22:16];
          end
          REG_D2: begin
            dw.stat <= host_wdata[3:0];
            dw.vid  <= host_wdata[23:12];
          end
          default: begin
            cmd_q  <= host_wdata[3:0];
            pen_q  <= host_wdata[4];
            port_q <= host_wdata[10:8];
          end
        endcase
      end
      if (start)         full_q <= 1'b0;
      else if (full_set) full_q <= 1'b1;
      rdata_q <= rd_mux;
    end
  end

  assign host_rdata = rdata_q;
  assign key_ent    = dw;
  assign fn_cmd     = cmd_q;
  assign fn_pen     = pen_q;
  assign fn_port    = port_q;
  assign tbl_full   = full_q;
endmodule

// File: rtl/atbl_seq.sv
module atbl_seq
  import atbl_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [3:0]         cmd,
  input  logic               pen,
  input  logic [PORT_W-1:0]  port,
  input  entry_t             key,
  output logic               busy,
  output logic [AW-1:0]      mem_raddr,
  input  logic [ENTRY_W-1:0] mem_rdata,
  output logic               mem_we,
  output logic [AW-1:0]      mem_waddr,
  output logic [ENTRY_W-1:0] mem_wdata,
  output logic               ret_vld,
  output entry_t             ret_ent,
  output logic               full_set
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_SCAN, S_FIN} st_e;

  st_e             st;
  logic [AW-1:0]   idx;
  logic            issuing;
  logic            ev_vld;
  logic [AW-1:0]   ev_idx;
  logic            armed;
  logic            hit;
  logic [AW-1:0]   hit_idx;
  logic            free_ok;
  logic [AW-1:0]   free_idx;

  entry_t              slot;
  entry_t              upd;
  logic                slot_vld;
  logic                key_hit;
  logic                port_ok;
  logic                early;
  logic [PMASK_W:0]    pm_ext;
  logic [PMASK_W-1:0]  new_mask;

  assign slot     = entry_t'(mem_rdata);
  assign slot_vld = slot.stat != STAT_EMPTY;
  assign key_hit  = slot_vld && (slot.mac == key.mac) && (slot.vid == key.vid);
  assign pm_ext   = {1'b0, slot.pmask};
  assign port_ok  = !pen || pm_ext[port];
  assign new_mask = pen ? (slot.pmask & ~(PMASK_W'(1) << port)) : '0;
  assign busy      = (st != S_IDLE);
  assign mem_raddr = idx;

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = ev_idx;
    mem_wdata = '0;
    ret_vld   = 1'b0;
    ret_ent   = key;
    full_set  = 1'b0;
    early     = 1'b0;
    upd       = slot;
    if (st == S_INIT) begin
      mem_we    = 1'b1;
      mem_waddr = idx;
    end else if (st == S_SCAN && ev_vld) begin
      case (cmd)
        OP_FLUSH: mem_we = slot_vld;
        OP_PURGE: mem_we = key_hit;
        OP_FLUSH_PORT: begin
          if (slot_vld && slot.stat != STAT_STATIC && port_ok) begin
            mem_we    = 1'b1;
            upd.pmask = new_mask;
            if (new_mask == '0) upd = '0;
            mem_wdata = upd;
          end
        end
        OP_SEARCH: begin
          if (key_hit) begin
            ret_vld = 1'b1;
            ret_ent = slot;
            early   = 1'b1;
          end
        end
        OP_NEXT: begin
          if (armed && slot_vld && port_ok) begin
            ret_vld = 1'b1;
            ret_ent = slot;
            early   = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (st == S_FIN) begin
      case (cmd)
        OP_LOAD: begin
          if (hit) begin
            mem_we    = 1'b1;
            mem_waddr = hit_idx;
            mem_wdata = key;
          end else if (free_ok) begin
            mem_we    = 1'b1;
            mem_waddr = free_idx;
            mem_wdata = key;
          end else begin
            full_set = 1'b1;
          end
        end
        OP_SEARCH, OP_NEXT: begin
          ret_vld       = 1'b1;
          ret_ent       = key;
          ret_ent.stat  = STAT_EMPTY;
          ret_ent.pmask = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_INIT;
      idx      <= '0;
      issuing  <= 1'b0;
      ev_vld   <= 1'b0;
      ev_idx   <= '0;
      armed    <= 1'b0;
      hit      <= 1'b0;
      hit_idx  <= '0;
      free_ok  <= 1'b0;
      free_idx <= '0;
    end else begin
      case (st)
        S_INIT: begin
          if (idx == LAST) begin
            st  <= S_IDLE;
            idx <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_IDLE: begin
          if (start) begin
            st      <= S_SCAN;
            idx     <= '0;
            issuing <= 1'b1;
            ev_vld  <= 1'b0;
            armed   <= (key == '0);
            hit     <= 1'b0;
            free_ok <= 1'b0;
          end
        end
        S_SCAN: begin
          ev_vld <= issuing;
          ev_idx <= idx;
          if (issuing) begin
            if (idx == LAST) issuing <= 1'b0;
            else             idx <= idx + 1'b1;
          end
          if (ev_vld) begin
            if (cmd == OP_LOAD) begin
              if (key_hit && !hit) begin
                hit     <= 1'b1;
                hit_idx <= ev_idx;
              end
              if (!slot_vld && !free_ok) begin
                free_ok  <= 1'b1;
                free_idx <= ev_idx;
              end
            end
            if (cmd == OP_NEXT && !armed && key_hit) armed <= 1'b1;
            if (early) begin
              st      <= S_IDLE;
              ev_vld  <= 1'b0;
              issuing <= 1'b0;
            end else if (ev_idx == LAST) begin
              st <= S_FIN;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/atbl_engine.sv
module atbl_engine
  import atbl_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_we,
  input  logic [1:0]  host_waddr,
  input  logic [31:0] host_wdata,
  input  logic [1:0]  host_raddr,
  output logic [31:0] host_rdata,
  output logic        busy
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic               start;
  entry_t             key_ent;
  logic [3:0]         fn_cmd;
  logic               fn_pen;
  logic [PORT_W-1:0]  fn_port;
  logic               tbl_full;
  logic               ret_vld;
  entry_t             ret_ent;
  logic               full_set;
  logic               mem_we;
  logic [AW-1:0]      mem_waddr;
  logic [AW-1:0]      mem_raddr;
  logic [ENTRY_W-1:0] mem_wdata;
  logic [ENTRY_W-1:0] mem_rdata;

  atbl_hostif u_host (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .busy(busy), .ret_vld(ret_vld), .ret_ent(ret_ent), .full_set(full_set),
    .start(start), .key_ent(key_ent), .fn_cmd(fn_cmd), .fn_pen(fn_pen),
    .fn_port(fn_port), .tbl_full(tbl_full)
  );

  atbl_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cmd(fn_cmd), .pen(fn_pen),
    .port(fn_port), .key(key_ent), .busy(busy),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .ret_vld(ret_vld), .ret_ent(ret_ent), .full_set(full_set)
  );

  atbl_mem #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/atbl_engine_chk.sv
module atbl_engine_chk
  import atbl_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               host_we,
  input logic [1:0]         host_waddr,
  input logic [31:0]        host_wdata,
  input logic [1:0]         host_raddr,
  input logic [31:0]        host_rdata,
  input logic               busy,
  input logic [ENTRY_W-1:0] key,
  input logic [3:0]         fn_cmd,
  input logic               mem_we,
  input logic               full
);
  localparam int LIMIT = DEPTH + 2;
  int  busy_run;
  logic unused_chk;
  assign unused_chk = ^host_wdata[30:0];

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= 0;
    else              busy_run <= busy_run + 1;
  end

  // R2: a start write makes busy high on the next cycle
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_waddr == REG_FN && host_wdata[FN_BUSY] && !busy) |=> busy);

  // R2: no busy period lasts longer than DEPTH+2 cycles
  a_r2_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy_run < LIMIT + 1);

  // R2: table memory is only written while busy
  a_r2_write_when_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R2: busy bit in the function word follows busy
  a_r2_rdata_busy: assert property (@(posedge clk) disable iff (rst)
    $past(host_raddr == REG_FN) |-> (host_rdata[FN_BUSY] == $past(busy)));

  // R3: cursor/key and command stay frozen during a run
  a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(key) && $stable(fn_cmd)));

  // R4: the full flag only rises at the end of a load
  a_r4_full_from_load: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> (fn_cmd == OP_LOAD));
endmodule

bind atbl_engine atbl_engine_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
  .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
  .busy(busy), .key(key_ent), .fn_cmd(fn_cmd), .mem_we(mem_we), .full(tbl_full)
);

// File: tb/sim_atbl_engine.sv
module sim_atbl_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [1:0]  host_waddr = '0;
  logic [31:0] host_wdata = '0;
  logic [1:0]  host_raddr = '0;
  logic [31:0] host_rdata;
  logic        busy;

  int ntest = 0;
  int nfail = 0;
  int cyc = 0;
  int          q_cyc[$];
  logic [31:0] q_exp[$];
  logic [1:0]  q_adr[$];
  string       q_tag[$];

  localparam logic [3:0] C_FLUSH = 4'd1, C_LOAD = 4'd2, C_PURGE = 4'd3,
                         C_FPORT = 4'd4, C_NEXT = 4'd6, C_SEARCH = 4'd7;
  localparam logic [47:0] MA = 48'h1122_3344_5566;
  localparam logic [47:0] MB = 48'hAABB_CCDD_EEFF;
  localparam logic [47:0] MC = 48'h0000_0000_0010;
  localparam logic [47:0] MS = 48'h0000_0000_0777;

  atbl_engine u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .busy(busy)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares read data against the queued expectations
  initial forever begin
    @(negedge clk);
    while (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
      ntest++;
      if (host_rdata !== q_exp[0]) begin
        nfail++;
        $display("FAIL %s: reg %0d got %h expected %h", q_tag[0], q_adr[0], host_rdata, q_exp[0]);
      end
      void'(q_cyc.pop_front()); void'(q_exp.pop_front());
      void'(q_adr.pop_front()); void'(q_tag.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  function automatic logic [31:0] w1f(input logic [47:0] m, input logic [6:0] pm);
    return {9'b0, pm, m[47:32]};
  endfunction
  function automatic logic [31:0] w2f(input logic [11:0] v, input logic [3:0] s);
    return {8'b0, v, 8'b0, s};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic put(input logic [47:0] m, input logic [11:0] v, input logic [6:0] pm, input logic [3:0] s);
    wr(2'd0, m[31:0]);
    wr(2'd1, w1f(m, pm));
    wr(2'd2, w2f(v, s));
  endtask

  task automatic kick(input logic [3:0] c, input logic pe, input logic [2:0] p);
    wr(2'd3, {1'b1, 20'b0, p, 3'b0, pe, c});
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic go(input logic [3:0] c, input logic pe, input logic [2:0] p);
    kick(c, pe, p);
    wait_idle();
  endtask

  task automatic chk(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    host_raddr = a;
    q_cyc.push_back(cyc + 1); q_exp.push_back(e); q_adr.push_back(a); q_tag.push_back(tag);
  endtask

  task automatic ent(input logic [47:0] m, input logic [11:0] v, input logic [6:0] pm,
                     input logic [3:0] s, input string tag);
    chk(2'd0, m[31:0], tag);
    chk(2'd1, w1f(m, pm), tag);
    chk(2'd2, w2f(v, s), tag);
  endtask

  task automatic dchk(input logic ok, input string tag, input int act, input int exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic find(input logic [47:0] m, input logic [11:0] v);
    put(m, v, 7'h00, 4'h0);
    go(C_SEARCH, 1'b0, 3'd0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    dchk(busy == 1'b1, "R11 busy during clear", int'(busy), 1);
    wait_idle();
    ent(48'h0, 12'h0, 7'h0, 4'h0, "R11 data words after reset");
    chk(2'd3, 32'h0, "R11 function word after reset");

    // loads
    put(MA, 12'd5, 7'h03, 4'd7);   go(C_LOAD, 1'b0, 3'd0);
    chk(2'd3, 32'h0000_0002, "R4 load no full");
    put(MB, 12'd9, 7'h04, 4'hF);   go(C_LOAD, 1'b0, 3'd0);
    put(MC, 12'd1, 7'h06, 4'd3);   go(C_LOAD, 1'b0, 3'd0);

    // search hit / miss, packing
    find(MA, 12'd5);
    ent(MA, 12'd5, 7'h03, 4'd7, "R6 R1 search hit A");
    find(48'h1, 12'd5);
    ent(48'h1, 12'd5, 7'h00, 4'd0, "R6 search miss");

    // get-next walk
    put(48'h0, 12'h0, 7'h0, 4'h0);
    go(C_NEXT, 1'b0, 3'd0); ent(MA, 12'd5, 7'h03, 4'd7, "R7 first from zero cursor");
    go(C_NEXT, 1'b0, 3'd0); ent(MB, 12'd9, 7'h04, 4'hF, "R7 second");
    go(C_NEXT, 1'b0, 3'd0); ent(MC, 12'd1, 7'h06, 4'd3, "R7 third");
    go(C_NEXT, 1'b0, 3'd0); ent(MC, 12'd1, 7'h00, 4'd0, "R7 end of table");

    // port filtered walk
    put(48'h0, 12'h0, 7'h0, 4'h0);
    go(C_NEXT, 1'b1, 3'd2); ent(MB, 12'd9, 7'h04, 4'hF, "R8 filtered first");
    go(C_NEXT, 1'b1, 3'd2); ent(MC, 12'd1, 7'h06, 4'd3, "R8 filtered second");
    go(C_NEXT, 1'b1, 3'd2); chk(2'd2, w2f(12'd1, 4'd0), "R8 filtered end");

    // overwrite same key
    put(MA, 12'd5, 7'h01, 4'd7);   go(C_LOAD, 1'b0, 3'd0);
    find(MA, 12'd5);
    chk(2'd1, w1f(MA, 7'h01), "R4 overwrite mask");
    put(MA, 12'd5, 7'h01, 4'd7);
    go(C_NEXT, 1'b0, 3'd0); chk(2'd0, MB[31:0], "R4 no duplicate after overwrite");

    // writes ignored while busy
    put(48'h99, 12'd2, 7'h0, 4'h0);
    kick(C_PURGE, 1'b0, 3'd0);
    wr(2'd0, 32'hDEAD_BEEF);
    wr(2'd3, 32'h8000_0001);
    wait_idle();
    chk(2'd0, 32'h0000_0099, "R3 data write ignored");
    chk(2'd3, 32'h0000_0003, "R3 function write ignored");
    find(MA, 12'd5);
    chk(2'd2, w2f(12'd5, 4'd7), "R3 no flush started");

    // purge
    put(MB, 12'd9, 7'h0, 4'h0);    go(C_PURGE, 1'b0, 3'd0);
    find(MB, 12'd9);  chk(2'd2, w2f(12'd9, 4'd0), "R5 purged entry gone");
    find(MC, 12'd1);  chk(2'd2, w2f(12'd1, 4'd3), "R5 other entry kept");

    // fill to full
    for (int i = 0; i < 6; i++) begin
      put(48'h100 + 48'(i), 12'd3, 7'h08, 4'd2);
      go(C_LOAD, 1'b0, 3'd0);
    end
    chk(2'd3, 32'h0000_0002, "R4 last free slot");
    put(48'h200, 12'd3, 7'h08, 4'd2); go(C_LOAD, 1'b0, 3'd0);
    chk(2'd3, 32'h0000_1002, "R4 full flag");
    find(48'h200, 12'd3);
    chk(2'd2, w2f(12'd3, 4'd0), "R4 full load not stored");
    chk(2'd3, 32'h0000_0007, "R4 full cleared by next start");

    // static entry, per-port flush
    put(48'h105, 12'd3, 7'h0, 4'h0); go(C_PURGE, 1'b0, 3'd0);
    put(MS, 12'd4, 7'h08, 4'hF);     go(C_LOAD, 1'b0, 3'd0);
    go(C_FPORT, 1'b1, 3'd3);
    find(48'h100, 12'd3); chk(2'd2, w2f(12'd3, 4'd0), "R10 emptied dynamic entry");
    find(MS, 12'd4);      ent(MS, 12'd4, 7'h08, 4'hF, "R10 static untouched");
    find(MC, 12'd1);      ent(MC, 12'd1, 7'h06, 4'd3, "R10 other port kept");
    go(C_FPORT, 1'b1, 3'd1);
    find(MC, 12'd1);      ent(MC, 12'd1, 7'h04, 4'd3, "R10 bit cleared");
    find(MA, 12'd5);      chk(2'd2, w2f(12'd5, 4'd7), "R10 mask 01 unaffected by port 1");
    go(C_FPORT, 1'b0, 3'd0);
    find(MA, 12'd5);      chk(2'd2, w2f(12'd5, 4'd0), "R10 all dynamic flushed");
    find(MS, 12'd4);      chk(2'd2, w2f(12'd4, 4'hF), "R10 static survives");

    // flush all
    go(C_FLUSH, 1'b0, 3'd0);
    put(48'h0, 12'h0, 7'h0, 4'h0);
    go(C_NEXT, 1'b0, 3'd0);
    ent(48'h0, 12'h0, 7'h0, 4'h0, "R9 table empty after flush all");
    find(MS, 12'd4);      chk(2'd2, w2f(12'd4, 4'd0), "R9 static removed");

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule